// File: doc/BRIEF.md
# GPIO Interrupt Trigger and Status Logic

This block turns the levels of a wide bank of general-purpose pins into interrupt requests. Every pin has its own trigger detector, set up by two configuration bits: one picks edge or level sensing, the other picks the polarity. When a pin's detector fires, the matching status bit is set and stays set. Software clears status bits by writing ones to a status word.

Status bits and enable bits are packed into words of a fixed width, so pin `n` sits in word `n / WORD_W` at bit `n % WORD_W`. Any status bit whose enable bit is also set counts as pending. The OR of all pending bits drives one registered interrupt line. The pin inputs are assumed to be synchronized to `clk` already. Register decode is done outside this block, which sees only per-word write strobes and a data bus.

Top module: `pin_event_unit`

## Requirements
- R1: With the mode bits {levelSel, invert} = 2'b00, a pin that is sampled 0 on one clock edge and 1 on the next sets its status bit. The bit is visible right after the second edge.
- R2: With mode 2'b01, a 1-to-0 change between two consecutive samples sets the pin's status bit.
- R3: With mode 2'b10, the status bit is set after every edge at which the pin is sampled 0.
- R4: With mode 2'b11, the status bit is set after every edge at which the pin is sampled 1, even when a clear is written on that same edge.
- R5: A status bit stays set until a clear strobe for its word arrives with a 1 in its bit position of `clrData`. A 0 in that position leaves the bit unchanged.
- R6: When a clear and a new event for the same bit arrive on the same edge, the bit stays set.
- R7: Status bits are set whether or not their enable bit is set. A pin whose enable is 0 never raises `irq`.
- R8: `irq` is a register. It is high in the cycle after the edge at which the status and enable registers have at least one bit set in both, across all words. Otherwise it is low.
- R9: An enable strobe for word w loads `enData` into the enable bits of pins w*WORD_W to w*WORD_W+WORD_W-1. The other words keep their enable bits.
- R10: `statusWords` bit n is the status of pin n. Bit positions at or above NUM_PINS in the last word always read 0.
- R11: Reset clears all status bits, all enable bits, the stored previous levels and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pinLevel | input | NUM_PINS | Synchronized pin levels |
| trigLevelSel | input | NUM_PINS | Per pin: 1 selects level sensing, 0 selects edge sensing |
| trigInvert | input | NUM_PINS | Per pin polarity bit of the trigger mode |
| clrWe | input | NUM_WORDS | Per-word clear strobe for the status bits |
| clrData | input | WORD_W | Clear mask; a 1 clears the matching bit |
| enWe | input | NUM_WORDS | Per-word load strobe for the enable bits |
| enData | input | WORD_W | Enable value loaded on a strobe |
| statusWords | output | NUM_WORDS*WORD_W | All status words, concatenated |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with 10 pins and 4-bit words. This gives three words, and the last one holds only two pins, so the padded bit positions and the word-strobe mapping are both exercised. At that size, every pin is swept through all four trigger modes. Every pairing of status pin and enable pin is also tried, to show that the enable mapping reaches `irq`. A long pseudo-random run follows, checked cycle by cycle against an arithmetic model kept in the bench.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  // Trigger mode code is {levelSel, invert}
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trigMode_e;

  // Per-word strobes passed from control to datapath
  typedef struct packed {
    logic clrStb;
    logic enStb;
  } wordStrobe_t;

endpackage

// File: rtl/pin_event_detect.sv
module pin_event_detect
  import pin_event_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic levelSel,
  input  logic invert,
  output logic hit
);

  logic prevQ;
  trigMode_e mode;

  // Level seen at the previous edge, used for edge sensing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevQ <= 1'b0;
    else        prevQ <= level;
  end

  assign mode = trigMode_e'({levelSel, invert});

  always_comb begin
    unique case (mode)
      TRIG_RISE: hit = level & ~prevQ;
      TRIG_FALL: hit = ~level & prevQ;
      TRIG_LOW:  hit = ~level;
      TRIG_HIGH: hit = level;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_event_pkg::*;
#(
  parameter int NUM_WORDS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_WORDS-1:0]          clrWe,
  input  logic [NUM_WORDS-1:0]          enWe,
  input  logic                          anyPending,
  output wordStrobe_t [NUM_WORDS-1:0]   strobes,
  output logic                          irq
);

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      strobes[w].clrStb = clrWe[w];
      strobes[w].enStb  = enWe[w];
    end
  end

  // Combined interrupt leaves through a flop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= anyPending;
  end

endmodule

// File: rtl/pin_event_dp.sv
module pin_event_dp
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS   = 94,
  parameter int WORD_W     = 32,
  parameter int NUM_WORDS  = 3,
  parameter int TOTAL_BITS = 96
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         pinLevel,
  input  logic [NUM_PINS-1:0]         trigLevelSel,
  input  logic [NUM_PINS-1:0]         trigInvert,
  input  wordStrobe_t [NUM_WORDS-1:0] strobes,
  input  logic [WORD_W-1:0]           clrData,
  input  logic [WORD_W-1:0]           enData,
  output logic [TOTAL_BITS-1:0]       statusFlat,
  output logic                        anyPending
);

  logic [TOTAL_BITS-1:0] pendingVec;

  for (genvar p = 0; p < TOTAL_BITS; p++) begin : g_bit
    localparam int WIDX = p / WORD_W;
    localparam int BIDX = p % WORD_W;
    if (p < NUM_PINS) begin : g_pin
      logic hit;
      logic statusQ;
      logic enQ;

      pin_event_detect u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pinLevel[p]),
        .levelSel (trigLevelSel[p]),
        .invert   (trigInvert[p]),
        .hit      (hit)
      );

      // Set wins over write-one-to-clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) statusQ <= 1'b0;
        else        statusQ <= (statusQ & ~(strobes[WIDX].clrStb & clrData[BIDX])) | hit;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    enQ <= 1'b0;
        else if (strobes[WIDX].enStb)  enQ <= enData[BIDX];
      end

      assign statusFlat[p] = statusQ;
      assign pendingVec[p] = statusQ & enQ;
    end else begin : g_pad
      assign statusFlat[p] = 1'b0;
      assign pendingVec[p] = 1'b0;
    end
  end

  assign anyPending = |pendingVec;

endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
  import pin_event_pkg::*;
#(
  parameter  int NUM_PINS   = 94,
  parameter  int WORD_W     = 32,
  localparam int NUM_WORDS  = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int TOTAL_BITS = NUM_WORDS * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pinLevel,
  input  logic [NUM_PINS-1:0]   trigLevelSel,
  input  logic [NUM_PINS-1:0]   trigInvert,
  input  logic [NUM_WORDS-1:0]  clrWe,
  input  logic [WORD_W-1:0]     clrData,
  input  logic [NUM_WORDS-1:0]  enWe,
  input  logic [WORD_W-1:0]     enData,
  output logic [TOTAL_BITS-1:0] statusWords,
  output logic                  irq
);

  wordStrobe_t [NUM_WORDS-1:0] strobes;
  logic anyPending;

  pin_event_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clrWe      (clrWe),
    .enWe       (enWe),
    .anyPending (anyPending),
    .strobes    (strobes),
    .irq        (irq)
  );

  pin_event_dp #(
    .NUM_PINS   (NUM_PINS),
    .WORD_W     (WORD_W),
    .NUM_WORDS  (NUM_WORDS),
    .TOTAL_BITS (TOTAL_BITS)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .pinLevel     (pinLevel),
    .trigLevelSel (trigLevelSel),
    .trigInvert   (trigInvert),
    .strobes      (strobes),
    .clrData      (clrData),
    .enData       (enData),
    .statusFlat   (statusWords),
    .anyPending   (anyPending)
  );

endmodule

// File: rtl/pin_event_checker.sv
module pin_event_checker #(
  parameter  int NUM_PINS   = 94,
  parameter  int WORD_W     = 32,
  localparam int NUM_WORDS  = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int TOTAL_BITS = NUM_WORDS * WORD_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PINS-1:0]   pinLevel,
  input logic [NUM_PINS-1:0]   trigLevelSel,
  input logic [NUM_PINS-1:0]   trigInvert,
  input logic [NUM_WORDS-1:0]  clrWe,
  input logic [WORD_W-1:0]     clrData,
  input logic [NUM_WORDS-1:0]  enWe,
  input logic [WORD_W-1:0]     enData,
  input logic [TOTAL_BITS-1:0] statusWords,
  input logic                  irq
);

  logic [TOTAL_BITS-1:0] clrMask;
  logic [TOTAL_BITS-1:0] enShadow;
  logic [NUM_PINS-1:0]   levelActive;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++)
      clrMask[w*WORD_W +: WORD_W] = clrWe[w] ? clrData : '0;
  end

  // Enable state rebuilt from the write strobes at the ports
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enShadow <= '0;
    else begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (enWe[w]) enShadow[w*WORD_W +: WORD_W] <= enData;
    end
  end

  assign levelActive = trigLevelSel & ~(pinLevel ^ trigInvert);

  assert_reset_clear_R11: assert property (@(posedge clk)
    !rst_n |-> (statusWords == '0 && !irq));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(statusWords) & ~$past(clrMask)) & ~statusWords) == '0));

  // Covers level-low (R3) as well
  assert_level_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statusWords[NUM_PINS-1:0] & $past(levelActive)) == $past(levelActive)));

  assert_irq_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == (|($past(statusWords & enShadow)))));

  if (TOTAL_BITS > NUM_PINS) begin : g_padChk
    assert_pad_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      statusWords[TOTAL_BITS-1:NUM_PINS] == '0);
  end

endmodule

bind pin_event_unit pin_event_checker #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pinLevel     (pinLevel),
  .trigLevelSel (trigLevelSel),
  .trigInvert   (trigInvert),
  .clrWe        (clrWe),
  .clrData      (clrData),
  .enWe         (enWe),
  .enData       (enData),
  .statusWords  (statusWords),
  .irq          (irq)
);

// File: tb/pin_event_unit_test.sv
module pin_event_unit_test;

  localparam int NP = 10;
  localparam int W  = 4;
  localparam int NW = (NP + W - 1) / W;
  localparam int TB = NW * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pinLevel = '0;
  logic [NP-1:0] lvlSel = '0;
  logic [NP-1:0] inv = '0;
  logic [NW-1:0] clrWe = '0;
  logic [W-1:0]  clrData = '0;
  logic [NW-1:0] enWe = '0;
  logic [W-1:0]  enData = '0;
  logic [TB-1:0] statusWords;
  logic irq;

  logic [NP-1:0] mStatus = '0;
  logic [NP-1:0] mEn = '0;
  logic [NP-1:0] mPrev = '0;
  logic mIrq = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  pin_event_unit #(.NUM_PINS(NP), .WORD_W(W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pinLevel     (pinLevel),
    .trigLevelSel (lvlSel),
    .trigInvert   (inv),
    .clrWe        (clrWe),
    .clrData      (clrData),
    .enWe         (enWe),
    .enData       (enData),
    .statusWords  (statusWords),
    .irq          (irq)
  );

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // One clock: advance the model at the edge, compare at the falling edge
  task automatic tick(input string tag);
    logic [NP-1:0] hits;
    logic [NP-1:0] clrM;
    logic [NP-1:0] newEn;
    @(posedge clk);
    newEn = mEn;
    for (int p = 0; p < NP; p++) begin
      clrM[p] = clrWe[p / W] & clrData[p % W];
      case ({lvlSel[p], inv[p]})
        2'b00:   hits[p] = pinLevel[p] & ~mPrev[p];
        2'b01:   hits[p] = ~pinLevel[p] & mPrev[p];
        2'b10:   hits[p] = ~pinLevel[p];
        default: hits[p] = pinLevel[p];
      endcase
      if (enWe[p / W]) newEn[p] = enData[p % W];
    end
    mIrq    = |(mStatus & mEn);
    mStatus = (mStatus & ~clrM) | hits;
    mEn     = newEn;
    mPrev   = pinLevel;
    @(negedge clk);
    check(tag, "status", 64'(statusWords), 64'(TB'(mStatus)));
    check(tag, "irq", 64'(irq), 64'(mIrq));
    clrWe = '0;
    enWe  = '0;
  endtask

  task automatic wipe(input string tag);
    lvlSel = '0; inv = '0; pinLevel = '0;
    clrWe = '1; clrData = '1; enWe = '1; enData = '0;
    tick(tag);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    string tg;
    logic [6:0] pat;
    repeat (3) @(negedge clk);
    check("R11", "status in reset", 64'(statusWords), 64'(0));
    check("R11", "irq in reset", 64'(irq), 64'(0));
    rst_n = 1'b1;
    tick("R11");

    // Every pin through every mode (R1 R2 R3 R4)
    pat = 7'b0100110;
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        case (m)
          0: tg = "R1";
          1: tg = "R2";
          2: tg = "R3";
          default: tg = "R4";
        endcase
        wipe(tg);
        lvlSel[p] = m[1]; inv[p] = m[0];
        enWe[p / W] = 1'b1; enData = W'(1 << (p % W));
        tick(tg);
        for (int s = 0; s < 7; s++) begin
          pinLevel[p] = pat[s];
          if (s == 4) begin clrWe = '1; clrData = '1; end
          tick(tg);
        end
      end
    end

    // R5: sticky until a one is written
    wipe("R5");
    pinLevel[3] = 1'b1;
    tick("R5"); tick("R5"); tick("R5");
    check("R5", "held bit", 64'(statusWords[3]), 64'(1));
    clrWe[0] = 1'b1; clrData = 4'b0111;
    tick("R5");
    check("R5", "zero-write keeps", 64'(statusWords[3]), 64'(1));
    clrWe[0] = 1'b1; clrData = 4'b1000;
    tick("R5");
    check("R5", "one-write clears", 64'(statusWords[3]), 64'(0));

    // R6: edge and clear on the same edge
    wipe("R6");
    tick("R6");
    pinLevel[5] = 1'b1; clrWe = '1; clrData = '1;
    tick("R6");
    check("R6", "collision keeps", 64'(statusWords[5]), 64'(1));

    // R4: level-high re-asserts under repeated clears
    wipe("R4");
    lvlSel[8] = 1'b1; inv[8] = 1'b1; pinLevel[8] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      clrWe = '1; clrData = '1;
      tick("R4");
      check("R4", "level reasserts", 64'(statusWords[8]), 64'(1));
    end

    // R7: status without enable
    wipe("R7");
    pinLevel[2] = 1'b1;
    tick("R7"); tick("R7");
    check("R7", "status set", 64'(statusWords[2]), 64'(1));
    check("R7", "irq quiet", 64'(irq), 64'(0));

    // R9: enable word mapping, seen through irq
    for (int p = 0; p < NP; p++) begin
      for (int q = 0; q < NP; q++) begin
        wipe("R9");
        lvlSel[p] = 1'b1; inv[p] = 1'b1; pinLevel[p] = 1'b1;
        enWe[q / W] = 1'b1; enData = W'(1 << (q % W));
        tick("R9"); tick("R9");
        check("R9", "irq by mapping", 64'(irq), 64'(p == q));
      end
    end

    // R8: OR across words and drop after clears
    wipe("R8");
    pinLevel[0] = 1'b1; pinLevel[9] = 1'b1;
    enWe = '1; enData = '1;
    tick("R8"); tick("R8");
    check("R8", "irq both", 64'(irq), 64'(1));
    clrWe[0] = 1'b1; clrData = 4'b0001;
    tick("R8"); tick("R8");
    check("R8", "irq last word", 64'(irq), 64'(1));
    clrWe[2] = 1'b1; clrData = 4'b0010;
    tick("R8");
    tick("R8");
    check("R8", "irq dropped", 64'(irq), 64'(0));

    // R10: padded positions stay zero with every pin set
    wipe("R10");
    lvlSel = '1;
    tick("R10");
    check("R10", "pad bits", 64'(statusWords), 64'(TB'({NP{1'b1}})));

    // Pseudo-random run against the model
    wipe("R8");
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
      pinLevel = lfsr[NP-1:0];
      if (lfsr[20:18] == 3'b000) begin lvlSel = lfsr[NP+9:10]; inv = lfsr[NP+11:12]; end
      clrWe = lfsr[23] ? lfsr[26:24] : '0;
      clrData = lfsr[30:27];
      enWe = (lfsr[21] & lfsr[17]) ? lfsr[NW-1+5:5] : '0;
      enData = lfsr[15:12];
      tick("R5");
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule